// File: doc/BRIEF.md
# Latency Estimator by Delay Matching

This block finds how many clock cycles of delay a device under test adds to a signal path. The bench or the surrounding logic feeds two signed sample streams with one shared sample-enable. The first is a zero-delay reference. The second is what the device under test produced from the same input. The reference runs down a chain of registers, so every possible delay from zero up to the largest one of interest is present as a tap at the same moment. On every enabled sample, each tap is compared with the device sample.

Each tap gets three things on each enabled sample. It gets a match flag, which is set when the two samples are within a small tolerance. It gets a confirmed-lock flag, which is set once the tap has matched for a programmable number of samples in a row. It also gets a running sum of absolute differences. A start pulse opens a measurement window that lasts a programmed number of enabled samples. When the window ends, the block reports the tap with the smallest sum as the latency. It raises a one-cycle valid and a flag that says whether any tap reached a confirmed lock. A monitor port shows any single tap, chosen by a select input.

Top module: `lat_est`

## Requirements
- R1: Tap 0 is the current reference input, with no delay. For k from 1 to MAX_LAT, tap k holds the reference value that arrived k enabled samples earlier. The chain shifts only on cycles with `smp_en` high.
- R2: `mon_out` shows the tap chosen by `mon_sel` without any register delay. Select values above MAX_LAT give zero.
- R3: On each rising edge where `smp_en` is high inside a window, `tap_match[k]` is updated to show whether |tap k − `dut_smp`| ≤ tolerance. The tolerance is `cmp_tol` in LSB (0, 1 or 2), and the code 3 acts as 2. On edges where `smp_en` is low, `tap_match` holds its value.
- R4: After a start pulse, tap k takes part only from the (k+1)-th enabled sample of the window. Before that its match flag reads 0 and it adds no error.
- R5: `tap_lock[k]` becomes 1 on the sample where tap k has matched on N consecutive eligible samples. It then stays 1 until the next start. N is `confirm_len`, clamped to the range 2 to 4. A mismatch resets the run.
- R6: Each tap sums |tap − `dut_smp`| over the window in an ACC_W-bit accumulator. The accumulator saturates at 2^ACC_W−1 and does not wrap. The reported latency is the tap with the smallest sum.
- R7: A start pulse clears every flag, run count, sum and the eligibility count. The window then covers exactly `win_len` enabled samples, with 0 treated as 1. Cycles with `smp_en` low are not counted and do not change any flag or sum.
- R8: Take the rising edge that takes in the last sample of the window. `lat_valid` goes high for exactly one cycle, starting at the next rising edge. `lat_out` changes only at that same edge.
- R9: When several taps share the smallest sum, the lowest tap index is reported.
- R10: `no_lock` is updated together with the result. It is 1 when no `tap_lock` bit was set at the end of the window, and it keeps its value until the next result.
- R11: While reset is active, and after it, `lat_valid`, `lat_out`, `no_lock`, `tap_match` and `tap_lock` are 0, and every delayed tap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that clears state and opens a window |
| smp_en | input | 1 | Sample enable shared by both streams |
| ref_smp | input | WIDTH | Zero-delay reference sample, signed |
| dut_smp | input | WIDTH | Device-under-test sample, signed |
| cmp_tol | input | 2 | Match tolerance in LSB (3 acts as 2) |
| confirm_len | input | 3 | Number of consecutive matches needed for a lock, clamped to 2..4 |
| win_len | input | WIN_W | Window length in enabled samples (0 acts as 1) |
| mon_sel | input | SEL_W | Tap routed to the monitor |
| mon_out | output | WIDTH | Selected tap value |
| tap_match | output | MAX_LAT+1 | Per-tap match flag from the latest enabled sample |
| tap_lock | output | MAX_LAT+1 | Per-tap confirmed-lock flag, sticky within a window |
| lat_out | output | SEL_W | Measured latency in cycles |
| lat_valid | output | 1 | One-cycle pulse when `lat_out` is updated |
| no_lock | output | 1 | No tap reached a confirmed lock in the last window |

## Verification
The bench targets these corner cases:

- **Deepest tap and eligibility.** The bench checks the deepest tap (15) and the per-sample growth of the eligible tap set right after start. A design that compares taps before they are filled would show stale match bits, and would mislock or pick the wrong tap.
- **Tolerance boundaries.** It tests the tolerance at its edges, including code 3, and runs that break a match sequence. An off-by-one in the difference compare, or a run counter that is not reset on a miss, would show up as wrong `tap_match` or `tap_lock` values.
- **Saturation.** A window of full-scale errors long enough to overflow every sum checks the saturating accumulator. A wrapping accumulator would name a tap other than 0.
- **Ties, enable gaps and window edge.** An all-equal window checks the tie rule: a design that prefers the highest index reports 15. Windows with enable gaps and a zero-length window check that only enabled samples count. Those cases also check that the valid pulse falls exactly one edge after the last sample.

// File: rtl/lat_pkg.sv
package lat_pkg;
  // largest tolerance accepted, in LSB
  localparam logic [1:0] TOL_MAX = 2'd2;
  // bounds on the consecutive-match run
  localparam logic [2:0] RUN_MIN = 3'd2;
  localparam logic [2:0] RUN_MAX = 3'd4;

  typedef logic [2:0] run_t;

  function automatic logic [1:0] clamp_tol(input logic [1:0] t);
    return (t > TOL_MAX) ? TOL_MAX : t;
  endfunction

  function automatic run_t clamp_run(input run_t r);
    if (r < RUN_MIN) return RUN_MIN;
    if (r > RUN_MAX) return RUN_MAX;
    return r;
  endfunction
endpackage

// File: rtl/lat_tap_chain.sv
module lat_tap_chain #(
  parameter int WIDTH   = 16,
  parameter int MAX_LAT = 15,
  parameter int SEL_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic [WIDTH-1:0]             din,
  input  logic [SEL_W-1:0]             mon_sel,
  output logic [MAX_LAT:0][WIDTH-1:0]  taps,
  output logic [WIDTH-1:0]             mon_out
);
  localparam int NPAD = 2 ** SEL_W;

  logic [MAX_LAT:1][WIDTH-1:0] dly_q, dly_d;
  logic [NPAD-1:0][WIDTH-1:0]  tap_pad;

  assign taps[0] = din;

  for (genvar k = 1; k <= MAX_LAT; k++) begin : g_stage
    assign taps[k]  = dly_q[k];
    assign dly_d[k] = shift_en ? taps[k-1] : dly_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  // pad the tap set to the select range so a plain index suffices
  for (genvar j = 0; j < NPAD; j++) begin : g_pad
    if (j <= MAX_LAT) begin : g_real
      assign tap_pad[j] = taps[j];
    end else begin : g_zero
      assign tap_pad[j] = '0;
    end
  end

  assign mon_out = tap_pad[mon_sel];

  // R1: one enabled shift moves the input into the first delayed stage
  a_r1_tap_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> taps[1] == $past(din));

  // R1: without an enable the deepest stage keeps its value
  a_r1_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(taps[MAX_LAT]));
endmodule

// File: rtl/lat_tap_cmp.sv
module lat_tap_cmp
  import lat_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             elig,
  input  logic [WIDTH-1:0] tap_val,
  input  logic [WIDTH-1:0] dut_val,
  input  logic [1:0]       tol_eff,
  input  run_t             run_eff,
  output logic             match_q,
  output logic             lock_q,
  output logic [ACC_W-1:0] acc_q
);
  localparam int DW = WIDTH + 1;

  logic signed [DW-1:0] dsub;
  logic [DW-1:0]        dmag;
  logic                 hit;
  logic [ACC_W:0]       acc_sum;
  run_t                 run_q, run_d, run_inc;
  logic                 match_d, lock_d;
  logic [ACC_W-1:0]     acc_d;

  always_comb begin
    dsub    = $signed({tap_val[WIDTH-1], tap_val}) - $signed({dut_val[WIDTH-1], dut_val});
    dmag    = dsub[DW-1] ? $unsigned(-dsub) : $unsigned(dsub);
    hit     = dmag <= {{(DW-2){1'b0}}, tol_eff};
    run_inc = (run_q >= RUN_MAX) ? RUN_MAX : run_q + 3'd1;
    acc_sum = {1'b0, acc_q} + {{(ACC_W+1-DW){1'b0}}, dmag};
  end

  always_comb begin
    match_d = match_q;
    lock_d  = lock_q;
    run_d   = run_q;
    acc_d   = acc_q;
    if (clr) begin
      match_d = 1'b0;
      lock_d  = 1'b0;
      run_d   = '0;
      acc_d   = '0;
    end else if (upd) begin
      if (elig) begin
        match_d = hit;
        run_d   = hit ? run_inc : '0;
        lock_d  = lock_q | (hit && (run_inc >= run_eff));
        acc_d   = acc_sum[ACC_W] ? {ACC_W{1'b1}} : acc_sum[ACC_W-1:0];
      end else begin
        match_d = 1'b0;
        run_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      lock_q  <= 1'b0;
      run_q   <= '0;
      acc_q   <= '0;
    end else begin
      match_q <= match_d;
      lock_q  <= lock_d;
      run_q   <= run_d;
      acc_q   <= acc_d;
    end
  end

  // R6: a sum never drops during a window
  a_r6_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> acc_q >= $past(acc_q));

  // R4: an excluded tap reports no match and adds nothing
  a_r4_excluded_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !elig && !clr) |=> (!match_q && $stable(acc_q)));

  // R5: a lock only appears on a sample that matched
  a_r5_lock_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> match_q);

  // R5: a lock holds until the next start
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !clr) |=> lock_q);
endmodule

// File: rtl/lat_pick.sv
module lat_pick #(
  parameter int NTAP  = 16,
  parameter int ACC_W = 24,
  parameter int SEL_W = 4
) (
  input  logic [NTAP-1:0][ACC_W-1:0] acc,
  output logic [SEL_W-1:0]           idx
);
  logic [ACC_W-1:0] best;

  // strict less-than keeps the lowest index on a tie
  always_comb begin
    best = acc[0];
    idx  = '0;
    for (int i = 1; i < NTAP; i++) begin
      if (acc[i] < best) begin
        best = acc[i];
        idx  = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/lat_est.sv
module lat_est
  import lat_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int MAX_LAT = 15,
  parameter int WIN_W   = 16,
  parameter int ACC_W   = 24,
  localparam int NTAP   = MAX_LAT + 1,
  localparam int SEL_W  = (NTAP > 1) ? $clog2(NTAP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             smp_en,
  input  logic [WIDTH-1:0] ref_smp,
  input  logic [WIDTH-1:0] dut_smp,
  input  logic [1:0]       cmp_tol,
  input  logic [2:0]       confirm_len,
  input  logic [WIN_W-1:0] win_len,
  input  logic [SEL_W-1:0] mon_sel,
  output logic [WIDTH-1:0] mon_out,
  output logic [NTAP-1:0]  tap_match,
  output logic [NTAP-1:0]  tap_lock,
  output logic [SEL_W-1:0] lat_out,
  output logic             lat_valid,
  output logic             no_lock
);
  localparam logic [SEL_W-1:0] FILL_TOP = SEL_W'(MAX_LAT);

  logic [MAX_LAT:0][WIDTH-1:0] taps;
  logic [NTAP-1:0][ACC_W-1:0]  acc_all;
  logic [NTAP-1:0]             elig;
  logic [SEL_W-1:0]            pick_idx;
  logic [1:0]                  tol_eff;
  run_t                        run_eff;
  logic                        upd;

  logic             active_q, active_d;
  logic [SEL_W-1:0] fill_q, fill_d;
  logic [WIN_W-1:0] win_cnt_q, win_cnt_d, win_eff;
  logic             finish_q, finish_d;
  logic [SEL_W-1:0] lat_q, lat_d;
  logic             valid_q, valid_d;
  logic             nl_q, nl_d;
  logic             last_smp;

  assign tol_eff = clamp_tol(cmp_tol);
  assign run_eff = clamp_run(confirm_len);
  assign upd     = active_q && smp_en && !start;

  lat_tap_chain #(.WIDTH(WIDTH), .MAX_LAT(MAX_LAT), .SEL_W(SEL_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (smp_en),
    .din      (ref_smp),
    .mon_sel  (mon_sel),
    .taps     (taps),
    .mon_out  (mon_out)
  );

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_first
      assign elig[k] = 1'b1;
    end else begin : g_later
      assign elig[k] = fill_q >= SEL_W'(k);
    end

    lat_tap_cmp #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .upd     (upd),
      .elig    (elig[k]),
      .tap_val (taps[k]),
      .dut_val (dut_smp),
      .tol_eff (tol_eff),
      .run_eff (run_eff),
      .match_q (tap_match[k]),
      .lock_q  (tap_lock[k]),
      .acc_q   (acc_all[k])
    );
  end

  lat_pick #(.NTAP(NTAP), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_pick (
    .acc (acc_all),
    .idx (pick_idx)
  );

  assign win_eff  = (win_len == '0) ? WIN_W'(1) : win_len;
  assign last_smp = (win_cnt_q == (win_eff - WIN_W'(1)));

  always_comb begin
    active_d  = active_q;
    fill_d    = fill_q;
    win_cnt_d = win_cnt_q;
    finish_d  = 1'b0;
    valid_d   = 1'b0;
    lat_d     = lat_q;
    nl_d      = nl_q;
    if (finish_q) begin
      valid_d = 1'b1;
      lat_d   = pick_idx;
      nl_d    = ~|tap_lock;
    end
    if (start) begin
      active_d  = 1'b1;
      fill_d    = '0;
      win_cnt_d = '0;
    end else if (smp_en) begin
      if (fill_q != FILL_TOP) fill_d = fill_q + SEL_W'(1);
      if (active_q) begin
        win_cnt_d = win_cnt_q + WIN_W'(1);
        if (last_smp) begin
          active_d = 1'b0;
          finish_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      fill_q    <= '0;
      win_cnt_q <= '0;
      finish_q  <= 1'b0;
      lat_q     <= '0;
      valid_q   <= 1'b0;
      nl_q      <= 1'b0;
    end else begin
      active_q  <= active_d;
      fill_q    <= fill_d;
      win_cnt_q <= win_cnt_d;
      finish_q  <= finish_d;
      lat_q     <= lat_d;
      valid_q   <= valid_d;
      nl_q      <= nl_d;
    end
  end

  assign lat_out   = lat_q;
  assign lat_valid = valid_q;
  assign no_lock   = nl_q;

  // independent check of the picked tap against every sum
  logic pick_ok;
  always_comb begin
    pick_ok = 1'b1;
    for (int i = 0; i < NTAP; i++) begin
      if (acc_all[i] < acc_all[pick_idx]) pick_ok = 1'b0;
      if ((SEL_W'(i) < pick_idx) && (acc_all[i] == acc_all[pick_idx])) pick_ok = 1'b0;
    end
  end

  // R9: the result is a minimum, and the lowest such index
  a_r9_lowest_min: assert property (@(posedge clk) disable iff (!rst_n)
    finish_q |-> pick_ok);

  // R8: the valid pulse lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lat_valid |=> !lat_valid);

  // R8: the result moves only with the valid pulse
  a_r8_result_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat_out) |-> lat_valid);

  // R10: the no-lock flag moves only with the valid pulse
  a_r10_nolock_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(no_lock) |-> lat_valid);
endmodule

// File: tb/lat_est_tb.sv
`timescale 1ns/1ps
module lat_est_tb_top;
  localparam int WIDTH = 16;
  localparam int NTAP  = 16;

  typedef struct packed {
    int lat; int off; int tol; int run; int win; int gap; int exp_lat; int exp_nl;
  } vec_t;

  // delay, offset, tolerance, run, window, gaps, expected latency, expected no_lock
  localparam vec_t VECS [7] = '{
    '{3,  0, 0, 2, 40, 0,  3, 0},
    '{0,  0, 0, 4, 20, 1,  0, 0},
    '{15, 0, 0, 3, 40, 0, 15, 0},
    '{7,  2, 2, 4, 30, 1,  7, 0},
    '{7,  2, 0, 2, 30, 0,  7, 1},
    '{5,  3, 3, 2, 30, 0,  5, 1},
    '{9, -1, 1, 7, 30, 1,  9, 0}
  };

  logic clk = 1'b0;
  logic rst_n, start, smp_en;
  logic [WIDTH-1:0] ref_smp, dut_smp;
  logic [1:0]  cmp_tol;
  logic [2:0]  confirm_len;
  logic [15:0] win_len;
  logic [3:0]  mon_sel;
  logic [WIDTH-1:0] mon_out;
  logic [NTAP-1:0]  tap_match, tap_lock;
  logic [3:0]  lat_out;
  logic        lat_valid, no_lock;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] hist [0:511];

  always #4 clk = ~clk;

  lat_est dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_en(smp_en),
    .ref_smp(ref_smp), .dut_smp(dut_smp), .cmp_tol(cmp_tol),
    .confirm_len(confirm_len), .win_len(win_len), .mon_sel(mon_sel),
    .mon_out(mon_out), .tap_match(tap_match), .tap_lock(tap_lock),
    .lat_out(lat_out), .lat_valid(lat_valid), .no_lock(no_lock)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] next_rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return {2'b00, lfsr[13:0]} - 16'd8192;
  endfunction

  task automatic pulse_start();
    start = 1'b1; smp_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic put(input logic [15:0] r, input logic [15:0] d);
    smp_en = 1'b1; ref_smp = r; dut_smp = d;
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  // mode 0: random reference, 1: constant equal, 2: full-scale error
  task automatic run_window(input int mode, input int win, input int lat, input int off,
                            input int gap, input int exp_lat, input int exp_nl, input string tag);
    pulse_start();
    for (int i = 0; i < ((win == 0) ? 1 : win); i++) begin
      logic [15:0] r, d;
      if (gap != 0 && (i % 3) == 2) begin
        smp_en = 1'b0; ref_smp = next_rnd(); dut_smp = next_rnd();
        @(negedge clk);
      end
      if (mode == 1) begin
        r = 16'd100; d = 16'd100;
      end else if (mode == 2) begin
        r = 16'h7FFF; d = 16'h8000;
      end else begin
        r = next_rnd();
        hist[i] = r;
        d = (i >= lat) ? hist[i-lat] + 16'(off) : next_rnd();
      end
      put(r, d);
    end
    chk({tag, " R8 valid not before edge after last sample"}, 32'(lat_valid), 0);
    @(negedge clk);
    chk({tag, " R8 valid pulse"}, 32'(lat_valid), 1);
    chk({tag, " R6 latency"}, 32'(lat_out), 32'(exp_lat));
    chk({tag, " R10 no_lock"}, 32'(no_lock), 32'(exp_nl));
    @(negedge clk);
    chk({tag, " R8 valid one cycle"}, 32'(lat_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; smp_en = 1'b0;
    ref_smp = '0; dut_smp = '0; cmp_tol = '0; confirm_len = 3'd2;
    win_len = 16'd10; mon_sel = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 lat_valid", 32'(lat_valid), 0);
    chk("R11 lat_out", 32'(lat_out), 0);
    chk("R11 no_lock", 32'(no_lock), 0);
    chk("R11 tap_match", 32'(tap_match), 0);
    chk("R11 tap_lock", 32'(tap_lock), 0);
    chk("R11 delayed tap cleared", 32'(mon_out), 0);

    // R1/R2: fill chain with i*7+1, then view each tap
    for (int i = 0; i < 16; i++) put(16'(i * 7 + 1), 16'd0);
    ref_smp = 16'd99;
    for (int k = 0; k < 16; k++) begin
      mon_sel = 4'(k);
      #1;
      chk($sformatf("R2 R1 monitor tap %0d", k), 32'(mon_out),
          (k == 0) ? 32'd99 : 32'((16 - k) * 7 + 1));
    end
    mon_sel = 4'd5;
    @(negedge clk);
    chk("R1 chain holds without enable", 32'(mon_out), 32'(11 * 7 + 1));

    // table-driven windows
    for (int v = 0; v < 7; v++) begin
      cmp_tol = 2'(VECS[v].tol);
      confirm_len = 3'(VECS[v].run);
      win_len = 16'(VECS[v].win);
      run_window(0, VECS[v].win, VECS[v].lat, VECS[v].off, VECS[v].gap,
                 VECS[v].exp_lat, VECS[v].exp_nl, $sformatf("vec%0d", v));
    end

    // R7 start clears; R4 eligibility; R5 confirmation; R3 tolerance
    cmp_tol = 2'd0; confirm_len = 3'd3; win_len = 16'd1000;
    chk("R7 lock set before start", 32'(tap_lock != 0), 1);
    pulse_start();
    chk("R7 start clears tap_match", 32'(tap_match), 0);
    chk("R7 start clears tap_lock", 32'(tap_lock), 0);
    put(16'd100, 16'd100);
    chk("R4 only tap0 after 1st sample", 32'(tap_match), 32'h0001);
    put(16'd100, 16'd100);
    chk("R4 taps 0-1 after 2nd sample", 32'(tap_match), 32'h0003);
    chk("R5 no lock after 2 of 3", 32'(tap_lock), 0);
    put(16'd100, 16'd100);
    chk("R4 taps 0-2 after 3rd sample", 32'(tap_match), 32'h0007);
    chk("R5 tap0 locks after 3", 32'(tap_lock), 32'h0001);
    smp_en = 1'b0; dut_smp = 16'd777;
    @(negedge clk);
    chk("R7 idle cycle keeps tap_match", 32'(tap_match), 32'h0007);
    put(16'd100, 16'd500);
    chk("R3 miss clears match", 32'(tap_match), 0);
    chk("R5 lock sticky over miss", 32'(tap_lock), 32'h0001);
    put(16'd100, 16'd100);
    chk("R4 taps 0-4 after 5th sample", 32'(tap_match), 32'h001F);
    put(16'd100, 16'd100);
    chk("R5 run restarted after miss", 32'(tap_lock), 32'h0001);
    put(16'd100, 16'd100);
    chk("R5 taps 1-4 lock after 3 more", 32'(tap_lock), 32'h001F);
    cmp_tol = 2'd1;
    put(16'd100, 16'd101);
    chk("R3 tol 1 accepts 1 LSB", 32'(tap_match), 32'h00FF);
    cmp_tol = 2'd0;
    put(16'd100, 16'd101);
    chk("R3 tol 0 rejects 1 LSB", 32'(tap_match), 0);
    cmp_tol = 2'd3;
    put(16'd100, 16'd102);
    chk("R3 tol code 3 accepts 2 LSB", 32'(tap_match), 32'h03FF);
    put(16'd100, 16'd103);
    chk("R3 tol code 3 rejects 3 LSB", 32'(tap_match), 0);

    // R9 tie: every tap sums to zero
    cmp_tol = 2'd0; confirm_len = 3'd2; win_len = 16'd20;
    run_window(1, 20, 0, 0, 0, 0, 0, "R9 tie lowest");

    // R6 saturation: every tap overflows, all saturate and tie
    win_len = 16'd300;
    run_window(2, 300, 0, 0, 0, 0, 1, "R6 saturate");
    repeat (3) @(negedge clk);
    chk("R10 no_lock holds after result", 32'(no_lock), 1);

    // R7 zero window length acts as one sample
    win_len = 16'd0;
    run_window(1, 0, 0, 0, 0, 0, 1, "R7 zero window");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule